// File: doc/BRIEF.md
# Stall Detector with Learned Threshold

This block watches the load on a stepper motor through a torque count that an upstream sensing stage delivers once per step, qualified by a one-cycle valid strobe. Each valid count can be multiplied by eight, with saturation, and is then compared against a 12-bit threshold. A scaled count below the threshold means the rotor is stalling. The result is latched into a sticky flag that stays set until software sends a clear pulse. A second output passes the flag on to a chip-level fault summary only when reporting is allowed.

The threshold can be loaded as two parts, a low byte and a high nibble. It can also be learned while the motor runs unloaded. A learn request starts a run that collects eight valid scaled counts. The run ends by loading half of their average into the threshold, setting a success flag and giving a one-cycle completion pulse, which lets the requesting register bit clear itself. If detection is switched off during the run, the run ends at once with a failure flag.

Top module: `stall_guard`

## Requirements
- R1: After reset the threshold reads 3, the held torque count reads 4095, and the stall flag, report output, learn busy, learn done, learn OK and learn failure outputs are all 0.
- R2: A cycle with `thr_lo_we` high loads `thr_wdata[7:0]` into threshold bits 7:0. A cycle with `thr_hi_we` high loads `thr_wdata[3:0]` into threshold bits 11:8. The new value is visible on `thr_value` after the next clock edge.
- R3: A valid sample with `det_en`=1 and no learning run in progress sets `stall_flag` on the next edge when the scaled count is strictly below the threshold. A scaled count equal to or above the threshold leaves the flag unchanged.
- R4: With `scale8`=1 the compared count is the input times 8, saturated to 4095. With `scale8`=0 the input is compared unchanged.
- R5: With `det_en`=0 no sample sets the stall flag.
- R6: The stall flag stays set until a `stall_clr` pulse, which clears it on the next edge. A detection in the same cycle as the clear wins, and the flag stays 1.
- R7: `stall_rpt` equals `stall_flag` while `rep_en`=1 and is 0 while `rep_en`=0.
- R8: A `learn_req` with `det_en`=1 and no run in progress raises `learn_busy` on the next edge and clears `learn_ok` and `learn_fail`. On the eighth valid sample of the run, the threshold becomes the sum of the eight scaled counts shifted right by 4. At the same edge `learn_busy` drops, `learn_ok` rises and `learn_done` pulses for one cycle.
- R9: If `det_en` is 0 while `learn_busy` is 1, the run ends on the next edge with `learn_fail`=1, `learn_ok`=0, a `learn_done` pulse and the threshold unchanged. A `learn_req` made while `det_en`=0 fails the same way.
- R10: While `learn_busy` is 1, samples never set the stall flag and threshold writes are ignored.
- R11: `trq_count` shows the raw, unscaled count of the most recent valid sample and keeps that value between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Stall detection enable |
| scale8 | input | 1 | Multiply the count by 8 before comparing |
| rep_en | input | 1 | Pass the stall flag on to the summary output |
| thr_lo_we | input | 1 | Write threshold bits 7:0 |
| thr_hi_we | input | 1 | Write threshold bits 11:8 |
| thr_wdata | input | 8 | Threshold write data |
| cnt_valid | input | 1 | Torque count strobe, one per step |
| cnt_in | input | 12 | Torque count |
| learn_req | input | 1 | Start a learning run |
| stall_clr | input | 1 | Clear pulse for the stall flag |
| stall_flag | output | 1 | Latched stall indication |
| stall_rpt | output | 1 | Stall flag gated for the fault summary |
| thr_value | output | 12 | Current threshold |
| trq_count | output | 12 | Last raw torque count |
| learn_busy | output | 1 | Learning run in progress |
| learn_done | output | 1 | One-cycle pulse when a run ends |
| learn_ok | output | 1 | Last run succeeded |
| learn_fail | output | 1 | Last run failed |

## Verification
The comparison is tried with counts one below, equal to, and one above the threshold, both unscaled and scaled by eight. These patterns separate a strict compare from a non-strict one and show where the shift happens. Counts of 511 and 600 with a threshold of 4095 tell saturation apart from wrap-around. A learning run with eight distinct counts, all below the current threshold, shows three things: the learned value comes from the sum shifted by four, detection is held off during the run, and a threshold write made mid-run is dropped. Dropping the enable mid-run, and requesting while disabled, separate the failure path from the success path.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic {
    LS_IDLE = 1'b0,
    LS_RUN  = 1'b1
  } learn_state_e;
endpackage

// File: rtl/count_scaler.sv
module count_scaler #(
  parameter int unsigned CW = 12,
  parameter int unsigned SH = 3
) (
  input  logic [CW-1:0] raw,
  input  logic          scale_en,
  output logic [CW-1:0] scaled
);
  generate
    if (SH == 0) begin : g_none
      assign scaled = raw;
    end else begin : g_shift
      logic [CW+SH-1:0] wide;
      logic             ovf;
      assign wide = {raw, {SH{1'b0}}};
      assign ovf  = |wide[CW+SH-1:CW];
      always_comb begin
        if (!scale_en)  scaled = raw;
        else if (ovf)   scaled = '1;
        else            scaled = wide[CW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/learn_engine.sv
module learn_engine
  import stall_pkg::*;
#(
  parameter int unsigned CW   = 12,
  parameter int unsigned NLOG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          en,
  input  logic          smp_valid,
  input  logic [CW-1:0] smp,
  output logic          busy,
  output logic          load,
  output logic [CW-1:0] thr_learned,
  output logic          ok,
  output logic          fail,
  output logic          done
);
  localparam int unsigned AW = CW + NLOG;

  learn_state_e    state_q, state_d;
  logic [AW-1:0]   acc_q, acc_d, sum_next, shifted;
  logic [NLOG-1:0] n_q, n_d;
  logic            ok_q, ok_d, fail_q, fail_d, done_q, done_d;

  assign sum_next    = acc_q + AW'(smp);
  assign shifted     = sum_next >> (NLOG + 1);
  assign thr_learned = shifted[CW-1:0];

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    n_d     = n_q;
    ok_d    = ok_q;
    fail_d  = fail_q;
    done_d  = 1'b0;
    load    = 1'b0;
    case (state_q)
      LS_IDLE: begin
        if (req) begin
          if (en) begin
            state_d = LS_RUN;
            acc_d   = '0;
            n_d     = '0;
            ok_d    = 1'b0;
            fail_d  = 1'b0;
          end else begin
            ok_d   = 1'b0;
            fail_d = 1'b1;
            done_d = 1'b1;
          end
        end
      end
      default: begin
        if (!en) begin
          state_d = LS_IDLE;
          fail_d  = 1'b1;
          done_d  = 1'b1;
        end else if (smp_valid) begin
          acc_d = sum_next;
          n_d   = n_q + NLOG'(1);
          if (n_q == '1) begin
            state_d = LS_IDLE;
            ok_d    = 1'b1;
            done_d  = 1'b1;
            load    = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_IDLE;
      acc_q   <= '0;
      n_q     <= '0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
      n_q     <= n_d;
      ok_q    <= ok_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == LS_RUN);
  assign ok   = ok_q;
  assign fail = fail_q;
  assign done = done_q;

  // R8
  ok_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && fail_q));
  // R8
  end_pulses_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  // R9
  drop_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> (!busy && fail_q));
endmodule

// File: rtl/stall_latch.sv
module stall_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  // R6
  clr_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/stall_guard.sv
module stall_guard #(
  parameter int unsigned CW      = 12,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned SH      = 3,
  parameter int unsigned NLOG    = 3,
  parameter int unsigned THR_RST = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            det_en,
  input  logic            scale8,
  input  logic            rep_en,
  input  logic            thr_lo_we,
  input  logic            thr_hi_we,
  input  logic [LO_W-1:0] thr_wdata,
  input  logic            cnt_valid,
  input  logic [CW-1:0]   cnt_in,
  input  logic            learn_req,
  input  logic            stall_clr,
  output logic            stall_flag,
  output logic            stall_rpt,
  output logic [CW-1:0]   thr_value,
  output logic [CW-1:0]   trq_count,
  output logic            learn_busy,
  output logic            learn_done,
  output logic            learn_ok,
  output logic            learn_fail
);
  localparam int unsigned HI_W = CW - LO_W;

  logic [1:0]    rs_q;
  logic          rst_s_n;
  logic [CW-1:0] thr_q, thr_d, cnt_q, cnt_d, scaled, thr_learned;
  logic          busy, load, stall_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  count_scaler #(.CW(CW), .SH(SH)) u_scale (
    .raw(cnt_in), .scale_en(scale8), .scaled(scaled)
  );

  learn_engine #(.CW(CW), .NLOG(NLOG)) u_learn (
    .clk(clk), .rst_n(rst_s_n), .req(learn_req), .en(det_en),
    .smp_valid(cnt_valid), .smp(scaled), .busy(busy), .load(load),
    .thr_learned(thr_learned), .ok(learn_ok), .fail(learn_fail),
    .done(learn_done)
  );

  assign stall_set = cnt_valid && det_en && !busy && (scaled < thr_q);

  stall_latch u_flag (
    .clk(clk), .rst_n(rst_s_n), .set(stall_set), .clr(stall_clr),
    .flag(stall_flag)
  );

  always_comb begin
    thr_d = thr_q;
    if (load) begin
      thr_d = thr_learned;
    end else if (!busy) begin
      if (thr_lo_we) thr_d[LO_W-1:0]  = thr_wdata;
      if (thr_hi_we) thr_d[CW-1:LO_W] = thr_wdata[HI_W-1:0];
    end
    cnt_d = cnt_valid ? cnt_in : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      thr_q <= CW'(THR_RST);
      cnt_q <= '1;
    end else begin
      thr_q <= thr_d;
      cnt_q <= cnt_d;
    end
  end

  assign thr_value  = thr_q;
  assign trq_count  = cnt_q;
  assign learn_busy = busy;
  assign stall_rpt  = stall_flag & rep_en;

  // R10
  thr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !load) |=> $stable(thr_q));
  // R10
  no_stall_learning_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !stall_flag) |=> !stall_flag);
  // R11
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cnt_valid |=> $stable(cnt_q));
endmodule

// File: tb/stall_guard_test.sv
module stall_guard_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic det_en = 0, scale8 = 0, rep_en = 0, thr_lo_we = 0, thr_hi_we = 0;
  logic [7:0] thr_wdata = '0;
  logic cnt_valid = 0, learn_req = 0, stall_clr = 0;
  logic [11:0] cnt_in = '0;
  logic stall_flag, stall_rpt, learn_busy, learn_done, learn_ok, learn_fail;
  logic [11:0] thr_value, trq_count;

  always #(CLK_NS/2) clk = ~clk;

  stall_guard uut (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .scale8(scale8), .rep_en(rep_en),
    .thr_lo_we(thr_lo_we), .thr_hi_we(thr_hi_we), .thr_wdata(thr_wdata),
    .cnt_valid(cnt_valid), .cnt_in(cnt_in), .learn_req(learn_req),
    .stall_clr(stall_clr), .stall_flag(stall_flag), .stall_rpt(stall_rpt),
    .thr_value(thr_value), .trq_count(trq_count), .learn_busy(learn_busy),
    .learn_done(learn_done), .learn_ok(learn_ok), .learn_fail(learn_fail)
  );

  typedef struct {
    bit    flag;
    int    thr;
    int    cnt;
    string tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0, failures = 0;
  int m_thr = 3, m_acc = 0, m_n = 0;
  bit m_flag = 0, m_busy = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares one cycle after each driven sample
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk({it.tag, " stall_flag"}, int'(stall_flag), int'(it.flag));
        chk({it.tag, " thr_value"}, int'(thr_value), it.thr);
        chk({it.tag, " R11 trq_count"}, int'(trq_count), it.cnt);
      end
    end
  end

  task automatic smp(int v, string tag);
    int sc;
    item_t it;
    @(negedge clk);
    cnt_valid = 1'b1;
    cnt_in = 12'(v);
    sc = scale8 ? ((v * 8 > 4095) ? 4095 : v * 8) : v;
    if (m_busy) begin
      m_acc += sc;
      m_n++;
      if (m_n == 8) begin
        m_thr = m_acc >> 4;
        m_busy = 0;
      end
    end else if (det_en && sc < m_thr) begin
      m_flag = 1;
    end
    @(posedge clk);
    it.flag = m_flag; it.thr = m_thr; it.cnt = v; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    cnt_valid = 1'b0;
  endtask

  task automatic wr(bit hi, int d);
    @(negedge clk);
    thr_wdata = 8'(d);
    thr_lo_we = !hi;
    thr_hi_we = hi;
    if (!m_busy) begin
      if (hi) m_thr = (m_thr & 255) | ((d & 15) << 8);
      else    m_thr = (m_thr & 3840) | (d & 255);
    end
    @(negedge clk);
    thr_lo_we = 0;
    thr_hi_we = 0;
  endtask

  task automatic clr();
    @(negedge clk);
    stall_clr = 1;
    @(negedge clk);
    stall_clr = 0;
    m_flag = 0;
    chk("R6 clear", int'(stall_flag), 0);
  endtask

  task automatic start_learn();
    @(negedge clk);
    learn_req = 1;
    @(negedge clk);
    learn_req = 0;
    if (det_en) begin
      m_busy = 1; m_acc = 0; m_n = 0;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 thr", int'(thr_value), 3);
    chk("R1 trq_count", int'(trq_count), 4095);
    chk("R1 flags", int'({stall_flag, stall_rpt, learn_busy, learn_done, learn_ok, learn_fail}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    det_en = 1; rep_en = 1;
    smp(2, "R3 below");
    @(negedge clk);
    chk("R7 rpt on", int'(stall_rpt), 1);
    rep_en = 0; #1;
    chk("R7 rpt off", int'(stall_rpt), 0);
    rep_en = 1;
    clr();
    smp(3, "R3 equal");

    // R2 split write: 0x134 = 308
    wr(0, 8'h34);
    wr(1, 8'h01);
    @(negedge clk);
    chk("R2 thr write", int'(thr_value), 308);
    smp(307, "R3 one below");
    clr();
    smp(308, "R3 at threshold");
    smp(309, "R3 above");

    // R6 clear and detection in the same cycle
    smp(10, "R3 set");
    @(negedge clk);
    stall_clr = 1; cnt_valid = 1; cnt_in = 12'd10;
    @(negedge clk);
    stall_clr = 0; cnt_valid = 0;
    chk("R6 set wins", int'(stall_flag), 1);
    clr();

    // R5 disabled
    det_en = 0;
    smp(0, "R5 disabled");
    det_en = 1;

    // R4 scaling
    scale8 = 1;
    smp(38, "R4 scaled 304");
    clr();
    smp(39, "R4 scaled 312");
    wr(0, 8'hFF);
    wr(1, 8'h0F);
    smp(511, "R4 scaled 4088");
    clr();
    smp(600, "R4 saturate");
    scale8 = 0;

    // R8 learning, R10 suppression and write block
    start_learn();
    chk("R8 busy", int'(learn_busy), 1);
    for (int i = 0; i < 4; i++) smp(200 + 10 * i, "R10 learn sample");
    wr(0, 8'h00);
    @(negedge clk);
    chk("R10 write ignored", int'(thr_value), 4095);
    for (int i = 4; i < 8; i++) smp(200 + 10 * i, "R8 learn sample");
    chk("R8 ok", int'({learn_busy, learn_ok, learn_fail, learn_done}), 4'b0101);
    chk("R8 thr", int'(thr_value), 117);
    @(negedge clk);
    chk("R8 done one cycle", int'(learn_done), 0);
    smp(116, "R3 learned thr");
    clr();

    // R9 enable drop mid-run
    start_learn();
    chk("R8 ok cleared", int'(learn_ok), 0);
    for (int i = 0; i < 3; i++) smp(50, "R10 sample");
    @(negedge clk);
    det_en = 0;
    @(negedge clk);
    m_busy = 0;
    chk("R9 drop", int'({learn_busy, learn_ok, learn_fail, learn_done}), 4'b0011);
    chk("R9 thr kept", int'(thr_value), 117);

    // R9 request while disabled
    @(negedge clk);
    det_en = 1;
    start_learn();
    start_learn();
    det_en = 0;
    @(negedge clk);
    m_busy = 0;
    chk("R9 drop2", int'(learn_fail), 1);
    start_learn();
    chk("R9 req disabled", int'({learn_busy, learn_fail, learn_done}), 3'b011);
    repeat (3) @(negedge clk);
    chk("R11 hold", int'(trq_count), 50);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule